// File: doc/BRIEF.md
# Four-Point 2D Forward Integer DCT

This block turns a 4x4 tile of signed 16-bit residual samples into 16 forward DCT coefficients. The results match a fixed-point integer model bit for bit. Rows of four samples arrive one per beat on a valid/ready stream. After the fourth row the block stops accepting input and runs two passes of a 1D butterfly transform. The first pass runs down the columns and its result is transposed. The second pass runs over the transposed tile and has no transpose after it.

The scaling is fixed and nonstandard. Each sample is multiplied by 16 before the first pass. A +1 bias goes on the top-left sample only, and only when that raw sample is nonzero. Each coefficient ends with an add-one, shift-right-by-two step. The coefficients leave as four row beats on a valid/ready output stream. Each output lane is 16 bits wide, or sign-extended to 32 bits when the WIDE_OUT parameter is set.

Top module: `fdct4x4`

## Requirements
- R1: Each input sample is shifted left by 4 bits before the first pass, and only the low 16 bits are kept (two's-complement wrap).
- R2: When the raw sample at row 0, column 0 is nonzero, 1 is added (16-bit wrap) to its prescaled value. No other sample gets the bias, and a zero top-left sample gets none.
- R3: The 1D transform forms s0=a0+a3, s1=a1+a2, s2=a1-a2 and s3=a0-a3 with 16-bit wrap. Even outputs are y0=(s0+s1)*11585 and y2=(s0-s1)*11585, where the sum and the difference are formed at 32 bits.
- R4: Odd outputs are y1=s3*15137+s2*6270 and y3=s3*6270-s2*15137, accumulated at 32 bits.
- R5: Every product is reduced by adding 8192 and shifting arithmetically right by 14, and only the low 16 bits are kept.
- R6: Pass one transforms each column over the four rows, and its 4x4 result is transposed. Pass two transforms each column of the transposed tile, and its result is not transposed.
- R7: Each coefficient v from pass two is replaced by (v+1)>>>2, with the add wrapping at 16 bits.
- R8: Input beat r carries row r, with column c at in_data[c*16 +: 16]. Output beat j carries pass-two outputs y_j for lanes 0..3, which is row-major coefficients 4j..4j+3, with lane m at out_data[m*W +: W].
- R9: in_ready is low from the cycle after the fourth row is accepted until the last output beat is accepted. out_valid never coexists with in_ready. A stalled output beat keeps its data stable.
- R10: With WIDE_OUT=1 (W=32), each output lane is the 16-bit coefficient sign-extended to 32 bits. With WIDE_OUT=0, W is 16.
- R11: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input row is present |
| in_ready | output | 1 | Block can accept a row |
| in_data | input | 64 | Four signed 16-bit samples, column 0 in the LSBs |
| out_valid | output | 1 | Coefficient row is present |
| out_ready | input | 1 | Consumer accepts the row |
| out_data | output | 4*W | Four signed coefficients, lane 0 in the LSBs |

## Verification
The assertions check the handshake on every cycle:
- input is held off while a tile is being transformed or drained;
- a stalled output row stays stable;
- the output rows advance in order;
- the block returns to loading after the fourth output beat.

The arithmetic can only be shown by the bench scenarios, which compare every coefficient against an integer model. That arithmetic covers the prescale and conditional DC bias, the wrap of the 16-bit butterfly, the rounding narrowing, the transpose placement and the final scaling. The scenarios use random tiles, full-scale positive and negative tiles, alternating extremes, and tiles whose top-left sample is zero or nonzero.

// File: rtl/fdct4_pkg.sv
package fdct4_pkg;
  localparam int SW    = 16;
  localparam int NPT   = 4;
  localparam int CBITS = 14;
  localparam logic signed [31:0] K_C8  = 32'sd15137;
  localparam logic signed [31:0] K_C16 = 32'sd11585;
  localparam logic signed [31:0] K_C24 = 32'sd6270;
  localparam logic signed [31:0] K_HALF = 32'sd1 <<< (CBITS - 1);

  typedef logic signed [SW-1:0] smp_t;
  typedef smp_t [NPT-1:0] quad_t;
  typedef quad_t [NPT-1:0] tile_t;

  // R1 R2: prescale by 16, optional +1 bias
  function automatic smp_t prescale(input smp_t raw, input logic bias_en);
    smp_t t;
    t = raw <<< 4;
    if (bias_en && (raw != '0)) t = t + smp_t'(1);
    return t;
  endfunction

  // R5: round to nearest, shift by CBITS, keep low 16 bits
  function automatic smp_t rnd_narrow(input logic signed [31:0] p);
    logic signed [31:0] t;
    t = (p + K_HALF) >>> CBITS;
    return t[SW-1:0];
  endfunction

  // R3 R4: four-point butterfly
  function automatic quad_t dct4_1d(input quad_t a);
    smp_t s0, s1, s2, s3;
    logic signed [31:0] w0, w1, w2, w3;
    quad_t y;
    s0 = a[0] + a[3];
    s1 = a[1] + a[2];
    s2 = a[1] - a[2];
    s3 = a[0] - a[3];
    w0 = 32'(s0);
    w1 = 32'(s1);
    w2 = 32'(s2);
    w3 = 32'(s3);
    y[0] = rnd_narrow((w0 + w1) * K_C16);
    y[2] = rnd_narrow((w0 - w1) * K_C16);
    y[1] = rnd_narrow(w3 * K_C8 + w2 * K_C24);
    y[3] = rnd_narrow(w3 * K_C24 - w2 * K_C8);
    return y;
  endfunction

  // R7: add one, arithmetic shift by two
  function automatic smp_t post_scale(input smp_t v);
    smp_t t;
    t = v + smp_t'(1);
    return t >>> 2;
  endfunction
endpackage

// File: rtl/fdct4_pass.sv
module fdct4_pass
  import fdct4_pkg::*;
#(
  parameter bit TRANSPOSE = 1'b0,
  parameter bit FINAL     = 1'b0
) (
  input  tile_t tin,
  output tile_t tout
);
  tile_t res;

  // Column-wise transform: lane c gathered across rows
  for (genvar c = 0; c < NPT; c++) begin : g_lane
    quad_t col, y;
    for (genvar r = 0; r < NPT; r++) begin : g_gather
      assign col[r] = tin[r][c];
    end
    assign y = dct4_1d(col);
    for (genvar j = 0; j < NPT; j++) begin : g_scatter
      assign res[j][c] = y[j];
    end
  end

  for (genvar r = 0; r < NPT; r++) begin : g_row
    for (genvar c = 0; c < NPT; c++) begin : g_col
      smp_t pick;
      if (TRANSPOSE) begin : g_tr
        assign pick = res[c][r];
      end else begin : g_st
        assign pick = res[r][c];
      end
      if (FINAL) begin : g_fs
        assign tout[r][c] = post_scale(pick);
      end else begin : g_nf
        assign tout[r][c] = pick;
      end
    end
  end
endmodule

// File: rtl/fdct4_widen.sv
module fdct4_widen
  import fdct4_pkg::*;
#(
  parameter int OLW = 32
) (
  input  quad_t               q,
  output logic [NPT*OLW-1:0]  wide
);
  for (genvar m = 0; m < NPT; m++) begin : g_lane
    if (OLW > SW) begin : g_ext
      assign wide[m*OLW +: OLW] = {{(OLW-SW){q[m][SW-1]}}, q[m]};
    end else begin : g_pass
      assign wide[m*OLW +: OLW] = q[m];
    end
  end
endmodule

// File: rtl/fdct4x4.sv
module fdct4x4
  import fdct4_pkg::*;
#(
  parameter bit WIDE_OUT = 1'b1,
  localparam int OLW = WIDE_OUT ? 32 : SW,
  localparam int RW  = $clog2(NPT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NPT*SW-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NPT*OLW-1:0] out_data
);
  typedef enum logic [1:0] {S_LOAD, S_P1, S_P2, S_EMIT} st_t;

  st_t            st;
  tile_t          tile, p1_out, p2_out;
  quad_t          row_pre;
  logic [RW-1:0]  in_row, out_row;

  // Named events used by the assertions
  logic in_fire, out_fire, last_in, last_out;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign last_in  = (in_row == RW'(NPT-1));
  assign last_out = (out_row == RW'(NPT-1));

  assign in_ready  = (st == S_LOAD);
  assign out_valid = (st == S_EMIT);

  // R1 R2: prescale incoming row; bias only on row 0, lane 0
  for (genvar c = 0; c < NPT; c++) begin : g_pre
    assign row_pre[c] = prescale(in_data[c*SW +: SW], (c == 0) && (in_row == '0));
  end

  // R6: transpose after pass one only; R7 scaling after pass two
  fdct4_pass #(.TRANSPOSE(1'b1), .FINAL(1'b0)) u_pass1 (.tin(tile), .tout(p1_out));
  fdct4_pass #(.TRANSPOSE(1'b0), .FINAL(1'b1)) u_pass2 (.tin(tile), .tout(p2_out));

  // R8 R10: row-major emission, lane widening
  fdct4_widen #(.OLW(OLW)) u_widen (.q(tile[out_row]), .wide(out_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_LOAD;
      in_row  <= '0;
      out_row <= '0;
      tile    <= '0;
    end else begin
      case (st)
        S_LOAD: if (in_fire) begin
          tile[in_row] <= row_pre;
          in_row       <= in_row + 1'b1;
          if (last_in) st <= S_P1;
        end
        S_P1: begin
          tile <= p1_out;
          st   <= S_P2;
        end
        S_P2: begin
          tile <= p2_out;
          st   <= S_EMIT;
        end
        default: if (out_fire) begin
          out_row <= out_row + 1'b1;
          if (last_out) st <= S_LOAD;
        end
      endcase
    end
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);                                            // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));     // R9
  AST_LAST_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && last_in) |=> !in_ready);                                 // R9
  AST_EMIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && last_out) |=> (in_ready && !out_valid));                // R9
  AST_ROW_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !last_out) |=> out_valid);                              // R8
endmodule

// File: tb/tb_fdct4x4.sv
module tb_fdct4x4;
  localparam int CLK_NS = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [4*W-1:0] out_data;

  int n_chk = 0;
  int n_err = 0;
  int raw [4][4];
  int expv [4][4];

  always #(CLK_NS/2) clk = ~clk;

  fdct4x4 dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
               .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
               .out_data(out_data));

  function automatic int w16(input int v);
    int t;
    t = v & 32'hFFFF;
    if (t >= 32768) t = t - 65536;
    return t;
  endfunction

  function automatic int rnd(input int p);
    return w16((p + 8192) >>> 14);
  endfunction

  // y selects the output index of the 1D transform over a0..a3
  function automatic int tf(input int a0, a1, a2, a3, input int y);
    int s0, s1, s2, s3;
    s0 = w16(a0 + a3); s1 = w16(a1 + a2);
    s2 = w16(a1 - a2); s3 = w16(a0 - a3);
    case (y)
      0: return rnd((s0 + s1) * 11585);
      1: return rnd(s3 * 15137 + s2 * 6270);
      2: return rnd((s0 - s1) * 11585);
      default: return rnd(s3 * 6270 - s2 * 15137);
    endcase
  endfunction

  task automatic build_expect();
    int p [4][4];
    int a [4][4];
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        p[r][c] = w16(raw[r][c] * 16);                        // R1
    if (raw[0][0] != 0) p[0][0] = w16(p[0][0] + 1);           // R2
    for (int c = 0; c < 4; c++)                               // pass one down columns
      for (int j = 0; j < 4; j++)
        a[j][c] = tf(p[0][c], p[1][c], p[2][c], p[3][c], j);
    for (int m = 0; m < 4; m++)                               // pass two over transposed
      for (int j = 0; j < 4; j++)
        expv[j][m] = w16(tf(a[m][0], a[m][1], a[m][2], a[m][3], j) + 1) >>> 2;  // R7
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic run_tile(input string tag, input int bp);
    logic [W-1:0] held;
    logic stalled;
    int j;
    build_expect();
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int c = 0; c < 4; c++) in_data[c*16 +: 16] = 16'(raw[r][c]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R9 ready low after fourth row"}, int'(in_ready), 0);
    j = 0; stalled = 1'b0; held = '0;
    while (j < 4) begin
      out_ready = (bp == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
      if (stalled) begin
        check({tag, " R9 stalled data stable"}, int'(out_data[W-1:0] == held), 1);
        stalled = 1'b0;
      end
      if (out_valid) begin
        check({tag, " R9 no ready while emitting"}, int'(in_ready), 0);
        if (out_ready) begin
          for (int m = 0; m < 4; m++)
            check({tag, " R3 R4 R5 R6 R7 R8 R10 coefficient"},
                  $signed(out_data[m*W +: W]), expv[j][m]);
          j++;
        end else begin
          held = out_data[W-1:0];
          stalled = 1'b1;
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check({tag, " R9 ready back after drain"}, int'(in_ready), 1);
  endtask

  task automatic fill(input int v);
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) raw[r][c] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11 in_ready after reset", int'(in_ready), 1);
    check("R11 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;

    fill(0);                    run_tile("R2 zero tile no bias", 0);
    fill(0); raw[0][0] = 1;     run_tile("R1 R2 unit DC bias", 0);
    fill(0); raw[0][1] = 1;     run_tile("R2 bias absent off corner", 0);
    fill(0); raw[0][0] = -1;    run_tile("R2 negative DC", 1);
    fill(32767);                run_tile("R1 full positive wrap", 0);
    fill(-32768);               run_tile("R1 full negative", 1);
    fill(2047);                 run_tile("R7 max unwrapped", 0);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        raw[r][c] = ((r + c) % 2 == 0) ? 2047 : -2048;
    run_tile("R3 R4 checkerboard", 1);
    fill(0); raw[3][0] = 1000; raw[0][3] = -700;
    run_tile("R6 transpose placement", 0);

    for (int t = 0; t < 40; t++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          case (t % 3)
            0: raw[r][c] = $urandom_range(0, 511) - 256;
            1: raw[r][c] = $urandom_range(0, 4095) - 2048;
            default: raw[r][c] = $urandom_range(0, 65535) - 32768;
          endcase
      run_tile("R5 R8 random tile", t % 2);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule